// File: doc/BRIEF.md
# CPU Next-Address Generator

This block forms the next 16-bit memory address of an 8-bit accumulator-style processor, one address per clock. It holds three address registers: the memory address register (`mar`, which also drives the address bus), the program counter (`pc`) and a delayed program counter (`dpc`) that keeps the value `pc` had before the last program-flow load. Each cycle a 4-bit operation code from the instruction sequencer selects how the next address is built. The sources are the current `mar` or `pc`, the stack pointer, two operand bytes, the data-in byte, the two index registers and a branch condition.

A small state machine drives the ready output `rdy_out`. It has three states. `ST_INIT` is entered in reset and drives ready low. `ST_RUN` drives ready high. `ST_BUBBLE` drives ready low for one cycle after a non-sequential load. The transitions are: `ST_INIT` to `ST_RUN` on the first clock after reset; `ST_RUN` to `ST_BUBBLE` when a non-sequential load is accepted; `ST_BUBBLE` to `ST_RUN` on the next clock. The registers load only while `rdy_in` is high. Tying `rdy_in` to `rdy_out` therefore inserts one wait cycle after every jump in the address stream.

When an interrupt is pending together with the break-vector qualifier, the program-counter step operation freezes. This lets the sequencer start interrupt entry without losing the return address.

Top module: `nxt_addr_unit`

## Requirements
- R1: While `rst` is high, every clock loads `mar`, `pc` and `dpc` with `reset_addr`, and `rdy_out` is low; `addr_out` shows the same value.
- R2: After `rst` falls, `rdy_out` stays low until the next clock edge and is high after it; with `rdy_in` low in that cycle no register changes.
- R3: Operation codes that take an address directly: 0 keeps `mar`, 1 gives `pc`, 2 gives {0x01, `stk_ptr`}, 3 gives {`opnd_hi`, `opnd_lo`}, 8 gives {0x00, `din`}, 9 and 10 give {`din`, `opnd_lo`}, 11 gives {`din`, `opnd_lo`} + 1.
- R4: Code 4 gives `mar` + 1, plus `din` sign-extended to 16 bits when `cond` is high. Code 5 gives `pc` + 1. Code 6 gives `mar` + 1 and code 7 gives `mar` - 1.
- R5: Codes 12 (index X) and 14 (index Y) give {0x00, (`din` + index) mod 256}, so the upper byte is 0x00. Codes 13 (X) and 15 (Y) give {`din`, `opnd_lo`} plus the zero-extended index as a full 16-bit sum.
- R6: Codes 3, 4, 5, 9 and 11 load both `mar` and `pc` with the next address, and `dpc` takes the old `pc`.
- R7: Codes 1, 2, 6, 7, 8, 10, 12, 13, 14 and 15 load only `mar`; code 0 loads nothing; in all of these `pc` and `dpc` keep their values.
- R8: After an accepted load with code 1, 2, 3, 8 to 15, or code 4 with `cond` high, `rdy_out` is low for exactly one cycle. After codes 0, 5, 6, 7 and code 4 with `cond` low it stays high.
- R9: With `irq_act` and `brk_qual` both high, code 5 leaves `mar`, `pc` and `dpc` unchanged and `next_addr` equals `mar`. With only one of the two high, code 5 advances normally.
- R10: While `rdy_in` is low, `mar`, `pc` and `dpc` hold their values whatever the operation code.
- R11: Increment, decrement and index sums wrap modulo 2^16: 0xFFFF + 1 gives 0x0000 and 0x0000 - 1 gives 0xFFFF.
- R12: `next_addr` is combinational and follows the present inputs in the same cycle. `addr_out` always equals `mar`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reset_addr | input | 16 | Address loaded into all registers during reset |
| brk_qual | input | 1 | Break-vector qualifier |
| irq_act | input | 1 | Interrupt pending |
| rdy_in | input | 1 | Register update enable |
| op | input | 4 | Next-address operation code |
| cond | input | 1 | Branch condition |
| din | input | 8 | Data-in byte |
| opnd_lo | input | 8 | Low operand byte |
| opnd_hi | input | 8 | High operand byte |
| stk_ptr | input | 8 | Stack pointer |
| idx_x | input | 8 | Index register X |
| idx_y | input | 8 | Index register Y |
| addr_out | output | 16 | Address bus (registered `mar`) |
| rdy_out | output | 1 | Ready; low one cycle after a non-sequential load |
| next_addr | output | 16 | Combinational next address |
| mar | output | 16 | Memory address register |
| pc | output | 16 | Program counter |
| dpc | output | 16 | Delayed program counter |

## Verification
Every one of the 16 operation codes is applied with operands chosen so that the sources cannot be confused. Different high and low operand bytes expose swapped halves, and a negative and a positive branch offset separate sign extension from zero extension. Index sums that carry past bit 7 show whether the zero-page forms truncate while the absolute forms carry into the upper byte. Taken and not-taken branches, together with the register-only versus flow codes, show whether the ready bubble and the `pc`/`dpc` update are keyed to the correct codes. The wait cycle is driven with an increment code, so an update that ignores `rdy_in` becomes visible. The three combinations of interrupt and qualifier around code 5, wrap at 0xFFFF and 0x0000, and a second reset with a different vector cover the remaining corners.

// File: rtl/nau_pkg.sv
package nau_pkg;

    typedef enum logic [3:0] {
        OP_HOLD   = 4'd0,
        OP_PC     = 4'd1,
        OP_STACK  = 4'd2,
        OP_CALL   = 4'd3,
        OP_BRANCH = 4'd4,
        OP_STEP   = 4'd5,
        OP_INC    = 4'd6,
        OP_DEC    = 4'd7,
        OP_ZP     = 4'd8,
        OP_JUMP   = 4'd9,
        OP_ABS    = 4'd10,
        OP_RET    = 4'd11,
        OP_ZPX    = 4'd12,
        OP_ABSX   = 4'd13,
        OP_ZPY    = 4'd14,
        OP_ABSY   = 4'd15
    } na_op_e;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_BUBBLE = 2'd2
    } rdy_state_e;

endpackage

// File: rtl/nau_addr_mux.sv
module nau_addr_mux
    import nau_pkg::*;
#(
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   STK_PAGE = 'h01,
    localparam int             AW       = 2 * DW
) (
    input  logic [3:0]    op,
    input  logic          cond,
    input  logic          hold,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] stk_ptr,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [AW-1:0] mar,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] na,
    output logic          ld_mar,
    output logic          ld_pc,
    output logic          jump
);

    localparam logic [DW-1:0] ZERO_PAGE = '0;

    logic [AW-1:0] mar_inc;
    logic [AW-1:0] abs_base;
    logic [AW-1:0] rel_ofs;
    logic [DW-1:0] zp_x;
    logic [DW-1:0] zp_y;

    always_comb begin
        mar_inc  = mar + AW'(1);
        abs_base = {din, opnd_lo};
        rel_ofs  = cond ? {{DW{din[DW-1]}}, din} : '0;
        zp_x     = din + idx_x;
        zp_y     = din + idx_y;
    end

    always_comb begin
        na     = mar;
        ld_mar = 1'b0;
        ld_pc  = 1'b0;
        jump   = 1'b0;
        unique case (na_op_e'(op))
            OP_HOLD: begin
                na = mar;
            end
            OP_PC: begin
                na = pc;        ld_mar = 1'b1; jump = 1'b1;
            end
            OP_STACK: begin
                na = {STK_PAGE, stk_ptr}; ld_mar = 1'b1; jump = 1'b1;
            end
            OP_CALL: begin
                na = {opnd_hi, opnd_lo};
                ld_mar = 1'b1; ld_pc = 1'b1; jump = 1'b1;
            end
            OP_BRANCH: begin
                na = mar_inc + rel_ofs;
                ld_mar = 1'b1; ld_pc = 1'b1; jump = cond;
            end
            OP_STEP: begin
                if (!hold) begin
                    na = pc + AW'(1); ld_mar = 1'b1; ld_pc = 1'b1;
                end
            end
            OP_INC: begin
                na = mar_inc;   ld_mar = 1'b1;
            end
            OP_DEC: begin
                na = mar - AW'(1); ld_mar = 1'b1;
            end
            OP_ZP: begin
                na = {ZERO_PAGE, din}; ld_mar = 1'b1; jump = 1'b1;
            end
            OP_JUMP: begin
                na = abs_base;
                ld_mar = 1'b1; ld_pc = 1'b1; jump = 1'b1;
            end
            OP_ABS: begin
                na = abs_base;  ld_mar = 1'b1; jump = 1'b1;
            end
            OP_RET: begin
                na = abs_base + AW'(1);
                ld_mar = 1'b1; ld_pc = 1'b1; jump = 1'b1;
            end
            OP_ZPX: begin
                na = {ZERO_PAGE, zp_x}; ld_mar = 1'b1; jump = 1'b1;
            end
            OP_ABSX: begin
                na = abs_base + {ZERO_PAGE, idx_x}; ld_mar = 1'b1; jump = 1'b1;
            end
            OP_ZPY: begin
                na = {ZERO_PAGE, zp_y}; ld_mar = 1'b1; jump = 1'b1;
            end
            OP_ABSY: begin
                na = abs_base + {ZERO_PAGE, idx_y}; ld_mar = 1'b1; jump = 1'b1;
            end
            default: begin
                na = mar;
            end
        endcase
    end

endmodule

// File: rtl/nau_rdy_fsm.sv
module nau_rdy_fsm
    import nau_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rdy_in,
    input  logic jump,
    output logic rdy_out
);

    rdy_state_e state_q;
    rdy_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_INIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   state_d = ST_RUN;
            ST_RUN:    state_d = (rdy_in && jump) ? ST_BUBBLE : ST_RUN;
            ST_BUBBLE: state_d = ST_RUN;
            default:   state_d = ST_INIT;
        endcase
    end

    always_comb begin
        rdy_out = (state_q == ST_RUN);
    end

endmodule

// File: rtl/nau_addr_regs.sv
module nau_addr_regs #(
    parameter  int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rdy_in,
    input  logic [AW-1:0] reset_addr,
    input  logic [AW-1:0] na,
    input  logic          ld_mar,
    input  logic          ld_pc,
    output logic [AW-1:0] mar,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] dpc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= reset_addr;
            pc  <= reset_addr;
            dpc <= reset_addr;
        end else if (rdy_in) begin
            if (ld_mar) mar <= na;
            if (ld_pc) begin
                pc  <= na;
                dpc <= pc;
            end
        end
    end

endmodule

// File: rtl/nxt_addr_unit.sv
module nxt_addr_unit #(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] STK_PAGE = 'h01,
    localparam int           AW       = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reset_addr,
    input  logic          brk_qual,
    input  logic          irq_act,
    input  logic          rdy_in,
    input  logic [3:0]    op,
    input  logic          cond,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] stk_ptr,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic [AW-1:0] addr_out,
    output logic          rdy_out,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] mar,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] dpc
);

    logic ld_mar;
    logic ld_pc;
    logic jump;
    logic hold;

    assign hold = irq_act & brk_qual;

    nau_addr_mux #(.DW(DW), .STK_PAGE(STK_PAGE)) u_mux (
        .op      (op),
        .cond    (cond),
        .hold    (hold),
        .din     (din),
        .opnd_lo (opnd_lo),
        .opnd_hi (opnd_hi),
        .stk_ptr (stk_ptr),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .mar     (mar),
        .pc      (pc),
        .na      (next_addr),
        .ld_mar  (ld_mar),
        .ld_pc   (ld_pc),
        .jump    (jump)
    );

    nau_addr_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rdy_in     (rdy_in),
        .reset_addr (reset_addr),
        .na         (next_addr),
        .ld_mar     (ld_mar),
        .ld_pc      (ld_pc),
        .mar        (mar),
        .pc         (pc),
        .dpc        (dpc)
    );

    nau_rdy_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .rdy_in  (rdy_in),
        .jump    (jump),
        .rdy_out (rdy_out)
    );

    assign addr_out = mar;

endmodule

// File: rtl/nau_chk.sv
module nau_chk
    import nau_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic          rdy_in,
    input logic [3:0]    op,
    input logic          cond,
    input logic          irq_act,
    input logic          brk_qual,
    input logic [AW-1:0] next_addr,
    input logic [AW-1:0] mar,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] dpc,
    input logic          rdy_out
);

    logic is_flow;
    logic is_data;
    logic is_jump;
    logic is_zp;
    logic frozen;

    always_comb begin
        frozen  = (op == OP_STEP) && irq_act && brk_qual;
        is_flow = (op == OP_CALL) || (op == OP_BRANCH) || (op == OP_JUMP) ||
                  (op == OP_RET)  || ((op == OP_STEP) && !frozen);
        is_data = (op == OP_PC)  || (op == OP_STACK) || (op == OP_INC)  ||
                  (op == OP_DEC) || (op == OP_ZP)    || (op == OP_ABS)  ||
                  (op == OP_ZPX) || (op == OP_ABSX)  || (op == OP_ZPY)  ||
                  (op == OP_ABSY);
        is_jump = (op == OP_PC)   || (op == OP_STACK) || (op == OP_CALL) ||
                  (op >= OP_ZP)   || ((op == OP_BRANCH) && cond);
        is_zp   = (op == OP_ZP) || (op == OP_ZPX) || (op == OP_ZPY);
    end

    assert_zp_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        is_zp |-> (next_addr[AW-1:DW] == '0));

    assert_flow_load_R6: assert property (@(posedge clk) disable iff (rst)
        (rdy_in && is_flow) |=>
            (mar == $past(next_addr)) && (pc == $past(next_addr)) && (dpc == $past(pc)));

    assert_data_only_R7: assert property (@(posedge clk) disable iff (rst)
        (rdy_in && is_data) |=>
            (mar == $past(next_addr)) && $stable(pc) && $stable(dpc));

    assert_rdy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (rdy_out && rdy_in && is_jump) |=> !rdy_out);

    assert_rdy_recover_R8: assert property (@(posedge clk) disable iff (rst)
        !rdy_out |=> rdy_out);

    assert_int_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rdy_in && frozen) |=> $stable(mar) && $stable(pc) && $stable(dpc));

    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        !rdy_in |=> $stable(mar) && $stable(pc) && $stable(dpc));

endmodule

bind nxt_addr_unit nau_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rdy_in    (rdy_in),
    .op        (op),
    .cond      (cond),
    .irq_act   (irq_act),
    .brk_qual  (brk_qual),
    .next_addr (next_addr),
    .mar       (mar),
    .pc        (pc),
    .dpc       (dpc),
    .rdy_out   (rdy_out)
);

// File: tb/nxt_addr_unit_tb.sv
`timescale 1ns/1ps
module nxt_addr_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] reset_addr;
    logic        brk_qual, irq_act, rdy_in, cond;
    logic [3:0]  op;
    logic [7:0]  din, opnd_lo, opnd_hi, stk_ptr, idx_x, idx_y;
    logic [15:0] addr_out, next_addr, mar, pc, dpc;
    logic        rdy_out;

    int total = 0;
    int bad   = 0;
    bit over  = 0;

    logic [15:0] m_mar, m_pc, m_dpc;

    always #5 clk = ~clk;
    assign rdy_in = rdy_out;

    nxt_addr_unit u_dut (
        .clk(clk), .rst(rst), .reset_addr(reset_addr), .brk_qual(brk_qual),
        .irq_act(irq_act), .rdy_in(rdy_in), .op(op), .cond(cond), .din(din),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .stk_ptr(stk_ptr), .idx_x(idx_x),
        .idx_y(idx_y), .addr_out(addr_out), .rdy_out(rdy_out),
        .next_addr(next_addr), .mar(mar), .pc(pc), .dpc(dpc)
    );

    // fields: op, cond, din, opnd_lo, opnd_hi, idx_x, idx_y, irq, brk
    localparam int NV = 18;
    localparam logic [46:0] TBL [0:NV-1] = '{
        {4'd6,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd7,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd1,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd2,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd3,  1'b0, 8'h00, 8'h34, 8'h12, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd5,  1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd4,  1'b1, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd4,  1'b0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd4,  1'b1, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd9,  1'b0, 8'h80, 8'h10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd11, 1'b0, 8'h20, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd8,  1'b0, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd12, 1'b0, 8'hF0, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0},
        {4'd13, 1'b0, 8'h12, 8'hF0, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0},
        {4'd14, 1'b0, 8'h81, 8'h00, 8'h00, 8'h00, 8'h90, 1'b0, 1'b0},
        {4'd15, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0},
        {4'd10, 1'b0, 8'h56, 8'h78, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd0,  1'b0, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 1'b0, 1'b0}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic string tag_of(input logic [3:0] o);
        if (o == 4'd4 || o == 4'd5 || o == 4'd6 || o == 4'd7) return "R4";
        if (o >= 4'd12) return "R5";
        return "R3";
    endfunction

    // reference address per the requirement text
    function automatic logic [15:0] ref_na(input logic [3:0] o, input logic c,
            input logic [7:0] d, lo, hi, x, y, input logic frz);
        case (o)
            4'd0:  return m_mar;
            4'd1:  return m_pc;
            4'd2:  return {8'h01, stk_ptr};
            4'd3:  return {hi, lo};
            4'd4:  return c ? m_mar + 16'd1 + {{8{d[7]}}, d} : m_mar + 16'd1;
            4'd5:  return frz ? m_mar : m_pc + 16'd1;
            4'd6:  return m_mar + 16'd1;
            4'd7:  return m_mar - 16'd1;
            4'd8:  return {8'h00, d};
            4'd9, 4'd10: return {d, lo};
            4'd11: return {d, lo} + 16'd1;
            4'd12: return {8'h00, 8'(d + x)};
            4'd13: return {d, lo} + {8'h00, x};
            4'd14: return {8'h00, 8'(d + y)};
            default: return {d, lo} + {8'h00, y};
        endcase
    endfunction

    // called at a negative edge with the block ready
    task automatic step(input logic [3:0] o, input logic c, input logic [7:0] d, lo, hi,
            x, y, input logic ir, bk, input string t);
        logic [15:0] e_na;
        logic        frz, flow, upd, jmp;
        op = o; cond = c; din = d; opnd_lo = lo; opnd_hi = hi;
        idx_x = x; idx_y = y; irq_act = ir; brk_qual = bk;
        #1;
        frz  = (o == 4'd5) && ir && bk;
        e_na = ref_na(o, c, d, lo, hi, x, y, frz);
        chk(next_addr, e_na, {t, " R12 next_addr"});
        flow = ((o == 4'd3) || (o == 4'd4) || (o == 4'd5) || (o == 4'd9) || (o == 4'd11)) && !frz;
        upd  = (o != 4'd0) && !frz;
        jmp  = (o == 4'd1) || (o == 4'd2) || (o == 4'd3) || (o >= 4'd8) || ((o == 4'd4) && c);
        @(posedge clk); #1;
        if (upd)  m_mar = e_na;
        if (flow) begin m_dpc = m_pc; m_pc = e_na; end
        chk(mar, m_mar, {t, " mar"});
        chk(addr_out, m_mar, {t, " R12 addr_out"});
        chk(pc,  m_pc,  {t, flow ? " R6 pc" : " R7 pc"});
        chk(dpc, m_dpc, {t, flow ? " R6 dpc" : " R7 dpc"});
        chk({15'd0, rdy_out}, {15'd0, !jmp}, {t, " R8 rdy_out"});
        if (jmp) begin
            op = 4'd6;
            @(posedge clk); #1;
            chk(mar, m_mar, {t, " R10 mar held in wait cycle"});
            chk(pc,  m_pc,  {t, " R10 pc held in wait cycle"});
            chk({15'd0, rdy_out}, 16'd1, {t, " R8 rdy_out back"});
        end
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; reset_addr = 16'hFFFC; op = 4'd0; cond = 0; din = 0;
        opnd_lo = 0; opnd_hi = 0; stk_ptr = 8'hFD; idx_x = 0; idx_y = 0;
        irq_act = 0; brk_qual = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mar, 16'hFFFC, "R1 mar in reset");
        chk(pc,  16'hFFFC, "R1 pc in reset");
        chk(dpc, 16'hFFFC, "R1 dpc in reset");
        chk(addr_out, 16'hFFFC, "R1 addr_out in reset");
        chk({15'd0, rdy_out}, 16'd0, "R1 rdy_out in reset");
        rst = 0; op = 4'd6;
        #1;
        chk({15'd0, rdy_out}, 16'd0, "R2 rdy_out before first edge");
        @(posedge clk); #1;
        chk({15'd0, rdy_out}, 16'd1, "R2 rdy_out after first edge");
        chk(mar, 16'hFFFC, "R2 mar unchanged");
        chk(pc,  16'hFFFC, "R2 pc unchanged");
        @(negedge clk);
        m_mar = 16'hFFFC; m_pc = 16'hFFFC; m_dpc = 16'hFFFC;

        for (int i = 0; i < NV; i++) begin
            logic [46:0] e;
            e = TBL[i];
            step(e[46:43], e[42], e[41:34], e[33:26], e[25:18], e[17:10], e[9:2],
                 e[1], e[0], tag_of(e[46:43]));
        end

        // R11 wrap at both ends
        step(4'd9, 0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, "R11 jump to top");
        step(4'd6, 0, 0, 0, 0, 0, 0, 0, 0, "R11 inc wraps");
        chk(mar, 16'h0000, "R11 mar after inc from FFFF");
        step(4'd7, 0, 0, 0, 0, 0, 0, 0, 0, "R11 dec wraps");
        chk(mar, 16'hFFFF, "R11 mar after dec from 0000");
        step(4'd5, 0, 0, 0, 0, 0, 0, 0, 0, "R11 pc step wraps");
        chk(pc, 16'h0000, "R11 pc after step from FFFF");

        // R9 interrupt hold combinations
        step(4'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 realign mar");
        step(4'd5, 0, 0, 0, 0, 0, 0, 1, 1, "R9 both high");
        chk(pc, 16'h0000, "R9 pc frozen");
        step(4'd5, 0, 0, 0, 0, 0, 0, 1, 0, "R9 irq only");
        chk(pc, 16'h0001, "R9 pc advances irq only");
        step(4'd5, 0, 0, 0, 0, 0, 0, 0, 1, "R9 qualifier only");
        chk(pc, 16'h0002, "R9 pc advances qualifier only");

        // R1 second reset with another vector
        rst = 1; reset_addr = 16'hFFFA; op = 4'd6;
        @(posedge clk); #1;
        chk(mar, 16'hFFFA, "R1 mar second reset");
        chk(pc,  16'hFFFA, "R1 pc second reset");
        chk(dpc, 16'hFFFA, "R1 dpc second reset");
        chk({15'd0, rdy_out}, 16'd0, "R1 rdy_out second reset");
        @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        chk({15'd0, rdy_out}, 16'd1, "R2 rdy_out after second reset");
        chk(mar, 16'hFFFA, "R2 mar held after second reset");

        finish_run();
    end

endmodule